// File: doc/BRIEF.md
# Memory Region Chip-Select Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and its memory devices. It splits the 64 KB address space into four 16 KB regions and picks the region from the two top address bits. The memory-request strobe qualifies every chip select. A build-time mask states which regions are populated and which of them holds the ROM. The block models each populated region internally. A RAM region is a synchronous write array. The ROM region is a fixed content pattern computed from the offset.

The block registers read data. The value appears on `rdata` one clock after a read with memory request active. It keeps that value until the next such read. An empty region reads as all ones and stores nothing. The ROM region has no write path. With the partial-decode build option set, the block drives one 4 KB RAM device on address bits 11..0 only, so each of its bytes answers at sixteen addresses.

Top module: `memsel_decoder`

## Requirements
- R1: With `mem_req` high and full decoding, `region_cs` has bit `addr[15:14]` set when that region's bit in `REGION_MASK` is 1. All bits are 0 when the region's mask bit is 0. The select is combinational, in the same cycle.
- R2: While `mem_req` is low, `region_cs` is all zero, whatever the address and strobes.
- R3: `rdata` changes only at a clock edge where `mem_req` and `rd_en` are both high. At every other edge it keeps its value.
- R4: A read of an unpopulated region returns FFh.
- R5: A write to an unpopulated region leaves no trace. A later read of that region gives FFh, and the RAM regions keep their contents.
- R6: The ROM region (index `ROM_IDX`, default 0) reads as (offset[7:0] XOR offset[13:8] XOR 5Ah), where offset = addr[13:0].
- R7: A write to the ROM region has no effect on what the ROM region reads back.
- R8: A write to a populated RAM region stores `wdata` at offset bits [STORE_AW-1:0] (default 8 bits). A later read returns it. Offset bits above that alias, and each RAM region keeps separate storage.
- R9: At most one bit of `region_cs` is high in any cycle.
- R10: With `PARTIAL_EN` set, any access with `mem_req` high selects `region_cs[0]` alone. It reaches one 4 KB RAM at addr[11:0], so addresses that differ only in bits 15..12 reach the same byte.
- R11: After reset, `rdata` is FFh and no select is active.
- R12: A write strobe while `mem_req` is low stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Memory request strobe, active high |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| addr | input | ADDR_W (16) | CPU address |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Registered read data |
| region_cs | output | 4 | One-hot region chip selects |

## Verification
The bench writes every modelled offset of all four regions. The ROM and the empty region get data that differs from the RAM pattern. It then reads everything back. A decoder that let writes reach the ROM or the empty region would show that data, and a select error would show one RAM region's bytes in another. ROM offsets with high bits set and RAM offsets above the modelled depth test the offset folding and aliasing. Reads and writes with `mem_req` low show that the strobe qualification holds: a missing qualification would either update `rdata` or store a byte. A second instance built for partial decoding is read through all sixteen aliases of each written byte. A decoder that used the upper address bits there would return stale data at some alias.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    typedef enum logic [1:0] {
        KIND_EMPTY = 2'd0,
        KIND_ROM   = 2'd1,
        KIND_RAM   = 2'd2
    } region_kind_e;

    // Classify a region index from the populated mask and the ROM position.
    function automatic region_kind_e kind_of(input int idx, input int rom_idx,
                                             input logic [31:0] mask);
        if (!mask[idx]) return KIND_EMPTY;
        if (idx == rom_idx) return KIND_ROM;
        return KIND_RAM;
    endfunction

endpackage

// File: rtl/memsel_region_dec.sv
module memsel_region_dec #(
    parameter int          ADDR_W      = 16,
    parameter int          SEL_W       = 2,
    parameter int          NREG        = 4,
    parameter logic [NREG-1:0] REGION_MASK = '1,
    parameter bit          PARTIAL_EN  = 1'b0
) (
    input  logic              mem_req,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   region_cs,
    output logic [SEL_W-1:0]  region_idx
);

    generate
        if (PARTIAL_EN) begin : g_partial
            // Single device: no address bit takes part in selection.
            logic unused_addr;
            assign unused_addr = ^addr;
            assign region_idx  = '0;
            always_comb begin
                region_cs    = '0;
                region_cs[0] = mem_req;
            end
        end else begin : g_full
            assign region_idx = addr[ADDR_W-1 -: SEL_W];
            always_comb begin
                region_cs = '0;
                if (mem_req && REGION_MASK[region_idx]) begin
                    region_cs[region_idx] = 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/memsel_ram_bank.sv
module memsel_ram_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/memsel_rom_pattern.sv
module memsel_rom_pattern #(
    parameter int          OFF_W = 14,
    parameter int          DW    = 8,
    parameter logic [DW-1:0] SEED  = 8'h5A
) (
    input  logic [OFF_W-1:0] off,
    output logic [DW-1:0]    data
);

    // Fold the offset onto the data width and mix in a fixed seed.
    always_comb begin
        data = SEED;
        for (int i = 0; i < OFF_W; i++) begin
            data[i % DW] = data[i % DW] ^ off[i];
        end
    end

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder #(
    parameter int              ADDR_W      = 16,
    parameter int              DATA_W      = 8,
    parameter int              SEL_W       = 2,
    parameter logic [(1<<SEL_W)-1:0] REGION_MASK = 4'b0111,
    parameter int              ROM_IDX     = 0,
    parameter logic [DATA_W-1:0] ROM_SEED    = 8'h5A,
    parameter int              STORE_AW    = 8,
    parameter bit              PARTIAL_EN  = 1'b0,
    parameter int              PD_AW       = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mem_req,
    input  logic                    rd_en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [(1<<SEL_W)-1:0]   region_cs
);

    import memsel_pkg::*;

    localparam int NREG  = 1 << SEL_W;
    localparam int OFF_W = ADDR_W - SEL_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [SEL_W-1:0]             region_idx;
    logic [NREG-1:0][DATA_W-1:0]  bank_rd;

    memsel_region_dec #(
        .ADDR_W      (ADDR_W),
        .SEL_W       (SEL_W),
        .NREG        (NREG),
        .REGION_MASK (REGION_MASK),
        .PARTIAL_EN  (PARTIAL_EN)
    ) u_dec (
        .mem_req    (mem_req),
        .addr       (addr),
        .region_cs  (region_cs),
        .region_idx (region_idx)
    );

    generate
        if (PARTIAL_EN) begin : g_pd
            memsel_ram_bank #(.AW(PD_AW), .DW(DATA_W)) u_pd_ram (
                .clk   (clk),
                .we    (region_cs[0] & wr_en),
                .addr  (addr[PD_AW-1:0]),
                .wdata (wdata),
                .rdata (bank_rd[0])
            );
            for (genvar r = 1; r < NREG; r++) begin : g_idle
                assign bank_rd[r] = '1;
            end
        end else begin : g_full
            for (genvar r = 0; r < NREG; r++) begin : g_reg
                localparam region_kind_e KIND = kind_of(r, ROM_IDX, 32'(REGION_MASK));
                if (KIND == KIND_ROM) begin : g_rom
                    memsel_rom_pattern #(.OFF_W(OFF_W), .DW(DATA_W), .SEED(ROM_SEED)) u_rom (
                        .off  (addr[OFF_W-1:0]),
                        .data (bank_rd[r])
                    );
                end else if (KIND == KIND_RAM) begin : g_ram
                    memsel_ram_bank #(.AW(STORE_AW), .DW(DATA_W)) u_ram (
                        .clk   (clk),
                        .we    (region_cs[r] & wr_en),
                        .addr  (addr[STORE_AW-1:0]),
                        .wdata (wdata),
                        .rdata (bank_rd[r])
                    );
                end else begin : g_empty
                    assign bank_rd[r] = '1;
                end
            end
        end
    endgenerate

    // Next-state: capture the selected region's byte on a qualified read.
    always_comb begin
        st_d = st_q;
        if (mem_req && rd_en) begin
            st_d.rdata = (|region_cs) ? bank_rd[region_idx] : '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk #(
    parameter int              ADDR_W      = 16,
    parameter int              DATA_W      = 8,
    parameter int              SEL_W       = 2,
    parameter logic [(1<<SEL_W)-1:0] REGION_MASK = 4'b0111,
    parameter bit              PARTIAL_EN  = 1'b0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mem_req,
    input logic                  rd_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [DATA_W-1:0]     rdata,
    input logic [(1<<SEL_W)-1:0] region_cs
);

    AST_CS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> region_cs == '0); // R2

    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_cs)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && rd_en) |=> $stable(rdata)); // R3

    AST_EMPTY_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && rd_en && region_cs == '0) |=> rdata == '1); // R4

    AST_EMPTY_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!PARTIAL_EN && mem_req && !REGION_MASK[addr[ADDR_W-1 -: SEL_W]]) |-> region_cs == '0); // R1

    AST_PD_SINGLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (PARTIAL_EN && mem_req) |-> region_cs == 1); // R10

endmodule

bind memsel_decoder memsel_decoder_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SEL_W       (SEL_W),
    .REGION_MASK (REGION_MASK),
    .PARTIAL_EN  (PARTIAL_EN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .region_cs (region_cs)
);

// File: tb/memsel_decoder_tb_top.sv
module memsel_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] MASK = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, rdata_pd;
    logic [3:0]  cs, cs_pd;

    int vec_cnt = 0;
    int bad_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memsel_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .region_cs(cs)
    );

    memsel_decoder #(.PARTIAL_EN(1'b1)) dut_pd_i (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_pd), .region_cs(cs_pd)
    );

    function automatic logic [7:0] exp_ram(input int r, input int off);
        return 8'((off * 7 + r * 31 + 3) & 255);
    endfunction

    function automatic logic [7:0] exp_rom(input logic [13:0] off);
        return off[7:0] ^ {2'b00, off[13:8]} ^ 8'h5A;
    endfunction

    function automatic logic [3:0] exp_cs(input int r);
        return MASK[r] ? 4'(1 << r) : 4'b0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vec_cnt++;
        if (got !== exp) begin
            bad_cnt++;
            $display("FAIL %s addr=%h got=%h exp=%h", req, addr, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; mem_req = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        mem_req = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic [3:0] c,
                           output logic [7:0] dpd, output logic [3:0] cpd);
        @(negedge clk);
        addr = a; mem_req = 1'b1; rd_en = 1'b1;
        #1;
        c = cs; cpd = cs_pd;
        @(negedge clk);
        d = rdata; dpd = rdata_pd;
        mem_req = 1'b0; rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad_cnt++;
            $display("FAIL watchdog got=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d, dpd;
        logic [3:0] c, cpd;
        logic [15:0] a;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rdata after reset", 32'(rdata), 32'hFF);
        chk("R11 no select after reset", 32'(cs), 32'h0);

        // Fill: RAM regions get the pattern, ROM and empty get its inverse.
        for (int r = 0; r < 4; r++) begin
            for (int o = 0; o < 256; o++) begin
                a = {2'(r), 6'b0, 8'(o)};
                do_write(a, (r == 1 || r == 2) ? exp_ram(r, o) : ~exp_ram(r, o));
            end
        end

        // R12: write strobe without memory request.
        @(negedge clk);
        addr = {2'd1, 6'b0, 8'd5}; wdata = ~exp_ram(1, 5); wr_en = 1'b1; mem_req = 1'b0;
        #1;
        chk("R2 no select on unqualified write", 32'(cs), 32'h0);
        @(negedge clk);
        wr_en = 1'b0;

        // Read back every modelled offset of every region.
        for (int r = 0; r < 4; r++) begin
            for (int o = 0; o < 256; o++) begin
                a = {2'(r), 6'b0, 8'(o)};
                do_read(a, d, c, dpd, cpd);
                chk("R1 region select", 32'(c), 32'(exp_cs(r)));
                if (r == 0)
                    chk("R6 R7 ROM content after write", 32'(d), 32'(exp_rom(a[13:0])));
                else if (r == 3)
                    chk("R4 R5 empty region", 32'(d), 32'hFF);
                else if (r == 1 && o == 5)
                    chk("R12 unqualified write ignored", 32'(d), 32'(exp_ram(r, o)));
                else
                    chk("R8 RAM readback", 32'(d), 32'(exp_ram(r, o)));
            end
        end

        // ROM offsets with the upper offset bits exercised.
        for (int k = 0; k < 256; k++) begin
            a = {2'd0, 8'(k), 6'(k)};
            do_read(a, d, c, dpd, cpd);
            chk("R6 ROM high offsets", 32'(d), 32'(exp_rom(a[13:0])));
        end

        // RAM offsets above the modelled depth alias onto the low bits.
        for (int k = 0; k < 16; k++) begin
            a = {2'd2, 6'(k + 1), 8'(k)};
            do_read(a, d, c, dpd, cpd);
            chk("R8 RAM offset alias", 32'(d), 32'(exp_ram(2, k)));
        end

        // R3: rdata holds without a qualified read.
        do_read({2'd2, 6'b0, 8'd9}, d, c, dpd, cpd);
        @(negedge clk);
        addr = {2'd1, 14'd0}; mem_req = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        chk("R3 hold with mem_req low", 32'(rdata), 32'(exp_ram(2, 9)));
        addr = {2'd0, 14'd3}; mem_req = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        chk("R3 hold with rd_en low", 32'(rdata), 32'(exp_ram(2, 9)));
        mem_req = 1'b0;

        // R2: selects stay low across the space while mem_req is low.
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            addr = 16'(k * 16'h1000 + k * 3); rd_en = k[0]; mem_req = 1'b0;
            #1;
            chk("R2 no select without request", 32'(cs), 32'h0);
            chk("R2 no partial select without request", 32'(cs_pd), 32'h0);
        end
        rd_en = 1'b0;

        // R10: partial decode, each byte reached through all sixteen aliases.
        for (int j = 0; j < 16; j++) begin
            do_write(16'((j << 12) | ((j * 273) & 16'hFFF)), 8'(8'hC0 ^ j));
        end
        for (int j = 0; j < 16; j++) begin
            for (int k = 0; k < 16; k++) begin
                a = 16'((k << 12) | ((j * 273) & 16'hFFF));
                do_read(a, d, c, dpd, cpd);
                chk("R10 partial alias data", 32'(dpd), 32'(8'hC0 ^ j));
                chk("R10 partial select", 32'(cpd), 32'h1);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule